// File: doc/BRIEF.md
# Sync-Aligned Conversion Start Generator

This block produces a periodic start pulse for a successive-approximation converter, timed from a local clock by a programmable period counter. Every node fed by the same start edge samples its input at the same instant. A conversion result is ready a programmable number of clock cycles after each start, and the block raises a result strobe in that cycle.

A system-wide synchronization pulse, such as a once-per-second mark from a master node or an external time reference, re-phases the local timer. The pulse is passed through a two-flop synchronizer and an edge detector. The cycle in which its rising edge is detected always carries a start pulse, and the period counts on from there. If that start falls inside a running period, the interval before it is shorter than nominal, which puts a spur in the sampled data. The result of that realigning conversion carries a flag so that later processing can handle the irregular interval.

Top module: `conv_start_gen`

## Requirements
- R1: While reset is held, start_o, result_vld_o and irregular_o are low. The first start_o pulse appears in the first cycle after the first clock edge that sees reset released.
- R2: Without synchronization, start_o pulses for one cycle every P cycles, where P is period_i. Values of period_i below 2 act as 2.
- R3: If sync_i is first seen high at clock edge e, after being low at the edge before, start_o is high in the cycle that follows edge e+1.
- R4: After a realigning start, start pulses continue every P cycles counted from that start.
- R5: A sync_i level held high for several cycles causes only one realignment.
- R6: result_vld_o pulses exactly C cycles after each start, where C is conv_time_i and a C of 0 acts as 1. If another start occurs less than C cycles after a start, the earlier conversion produces no strobe.
- R7: irregular_o is high together with the result of a realigning start that cut the running interval short. It stays low when the sync edge falls on a cycle that would have started a conversion anyway.
- R8: irregular_o is never high without result_vld_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Global synchronization pulse, asynchronous |
| period_i | input | CNT_W | Nominal cycles between start pulses |
| conv_time_i | input | DLY_W | Cycles from a start to its result |
| start_o | output | 1 | Conversion start pulse |
| result_vld_o | output | 1 | Conversion result ready strobe |
| irregular_o | output | 1 | Marks the result that closes an irregular interval |

## Verification
The hardest cases to reach are the phase relationships between the sync edge and the free-running timer. These include a sync edge landing exactly on a natural start, where no flag may appear, and a sync edge that cuts off a conversion still in flight. The stimulus reaches every phase by placing the sync edge at each offset inside a period, for every small period and conversion time. Each case begins with a fresh reset, so the timer phase at the sync edge is known exactly.

// File: rtl/csg_pkg.sv
package csg_pkg;
  // Start event passed from the period timer to the conversion tracker.
  typedef struct packed {
    logic fire;       // a conversion starts in this cycle
    logic shortened;  // the start cut the running interval short
  } start_evt_t;
endpackage

// File: rtl/csg_sync_edge.sv
module csg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/csg_period_timer.sv
module csg_period_timer
  import csg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             realign_i,
  output start_evt_t       evt_o
);
  localparam logic [CNT_W-1:0] MIN_RELOAD = CNT_W'(1);

  // Cycles left after a start until the next one; a period below 2 acts as 2.
  function automatic logic [CNT_W-1:0] reload_val(input logic [CNT_W-1:0] p);
    if (p < CNT_W'(2)) return MIN_RELOAD;
    return p - CNT_W'(1);
  endfunction

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero        = (cnt == '0);
  assign evt_o.fire      = run & (cnt_zero | realign_i);
  assign evt_o.shortened = run & realign_i & ~cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      run <= 1'b1;
      if (evt_o.fire)  cnt <= reload_val(period_i);
      else if (run)    cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/csg_conv_delay.sv
module csg_conv_delay
  import csg_pkg::*;
#(
  parameter int DLY_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  start_evt_t       evt_i,
  input  logic [DLY_W-1:0] conv_time_i,
  output logic             vld_o,
  output logic             irr_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  // A conversion time of zero acts as one cycle.
  function automatic logic [DLY_W-1:0] load_val(input logic [DLY_W-1:0] c);
    return (c == '0) ? ONE : c;
  endfunction

  logic             busy;
  logic [DLY_W-1:0] dcnt;
  logic             irr_q;
  logic             done;

  assign done  = busy & (dcnt == ONE);
  assign vld_o = done;
  assign irr_o = done & irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy  <= 1'b0;
      dcnt  <= '0;
      irr_q <= 1'b0;
    end else if (evt_i.fire) begin
      busy  <= 1'b1;
      dcnt  <= load_val(conv_time_i);
      // A flag from an aborted conversion carries over to the next result.
      irr_q <= evt_i.shortened | (irr_q & busy & ~done);
    end else if (done) begin
      busy  <= 1'b0;
      irr_q <= 1'b0;
    end else if (busy) begin
      dcnt  <= dcnt - ONE;
    end
  end
endmodule

// File: rtl/conv_start_gen.sv
module conv_start_gen
  import csg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DLY_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [DLY_W-1:0] conv_time_i,
  output logic             start_o,
  output logic             result_vld_o,
  output logic             irregular_o
);
  logic       sync_det;
  start_evt_t start_evt;

  csg_sync_edge #(.STAGES(SYNC_STAGES)) sync_i0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_i),
    .rise_o  (sync_det)
  );

  csg_period_timer #(.CNT_W(CNT_W)) timer_i0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (period_i),
    .realign_i (sync_det),
    .evt_o     (start_evt)
  );

  csg_conv_delay #(.DLY_W(DLY_W)) delay_i0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (start_evt),
    .conv_time_i (conv_time_i),
    .vld_o       (result_vld_o),
    .irr_o       (irregular_o)
  );

  assign start_o = start_evt.fire;
endmodule

// File: rtl/csg_checker.sv
module csg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_det,
  input logic start_o,
  input logic result_vld_o,
  input logic irregular_o
);
  // R3
  sync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_det |-> start_o);

  // R5
  single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_det |=> !sync_det);

  // R2
  no_double_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (!start_o || sync_det));

  // R8
  irr_with_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irregular_o |-> result_vld_o);
endmodule

bind conv_start_gen csg_checker chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_det     (sync_det),
  .start_o      (start_o),
  .result_vld_o (result_vld_o),
  .irregular_o  (irregular_o)
);

// File: tb/conv_start_gen_tb_top.sv
module conv_start_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0;
  logic [15:0] period_i = 16'd4;
  logic [11:0] conv_time_i = 12'd1;
  logic        start_o, result_vld_o, irregular_o;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #10 clk_i = ~clk_i;

  conv_start_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .period_i(period_i),
    .conv_time_i(conv_time_i), .start_o(start_o),
    .result_vld_o(result_vld_o), .irregular_o(irregular_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Expected start in cycle n, given sync detection cycle d and period pe.
  function automatic bit exp_start(input int n, input int d, input int pe);
    if (n < d) return (n % pe) == 0;
    return ((n - d) % pe) == 0;
  endfunction

  task automatic run_cfg(input int p, input int c, input int off);
    int pe, ce, d, m, last;
    bit es, ev, ei, any;
    string lbl;
    pe = (p < 2) ? 2 : p;
    ce = (c < 1) ? 1 : c;
    d  = 2 * pe + off;
    m  = d - 2;
    last = d + 3 * pe + ce + 2;
    rst_ni = 1'b0; sync_i = 1'b0;
    period_i = 16'(p); conv_time_i = 12'(c);
    repeat (3) @(negedge clk_i);
    // R1: quiet outputs while reset is held
    chk(!start_o && !result_vld_o && !irregular_o, "R1",
        {29'd0, start_o, result_vld_o, irregular_o}, 0);
    rst_ni = 1'b1;
    for (int n = 0; n <= last; n++) begin
      @(negedge clk_i);
      es = exp_start(n, d, pe);
      if (n == 0)                  lbl = "R1";
      else if (n < d)              lbl = "R2";
      else if (n == d)             lbl = "R3";
      else if (n <= m + 4)         lbl = "R5";
      else                         lbl = "R4";
      chk(start_o == es, lbl, int'(start_o), int'(es));
      ev = 1'b0;
      if (n - ce >= 0 && exp_start(n - ce, d, pe)) begin
        any = 1'b0;
        for (int k = n - ce + 1; k < n; k++) if (exp_start(k, d, pe)) any = 1'b1;
        ev = !any;
      end
      chk(result_vld_o == ev, "R6", int'(result_vld_o), int'(ev));
      ei = (off != 0) && (n == d + ce);
      chk(irregular_o == ei, "R7", int'(irregular_o), int'(ei));
      chk(!(irregular_o && !result_vld_o), "R8", int'(irregular_o), int'(result_vld_o));
      if (n == m)     sync_i = 1'b1;
      if (n == m + 3) sync_i = 1'b0;
    end
  endtask

  initial begin
    for (int p = 1; p <= 6; p++)
      for (int c = 0; c < p; c++)
        for (int off = 0; off < ((p < 2) ? 2 : p); off++)
          run_cfg(p, c, off);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule